// File: doc/BRIEF.md
# System Control Register Pair with Guarded Writes

This block keeps two 64-bit system control registers: a mode-control register (paging, protection, cache disable and a legacy bit that is kept but has no effect) and a feature-enable register (eleven feature switches). A write arrives on a valid/ready port as a register select plus a 64-bit data word. Before any state changes, the block checks the word against mode and cross-bit rules. A write that breaks a rule is dropped whole and answered with a fault pulse. A write that passes updates the selected register and is answered with an accept pulse.

The stored bits drive decoded enables used by the rest of the core. Two helper paths are combinational. One decides whether a time-stamp counter read is allowed at the current privilege level. The other maps a debug register index to the register that is actually accessed, or flags an invalid-opcode case.

The write port never pushes back except during reset. `wr_ready` is low while `rst_n` is low and high from the first clock edge after reset is released. A write takes place on each clock edge where `wr_valid` and `wr_ready` are both high. The sender may hold `wr_valid` high for many cycles in a row, and each such cycle is a separate write.

Top module: `ctl_regfile`

## Requirements
- R1: After reset the mode-control register reads 64'h1, so only the protection-enable bit (bit 0) is set. The feature register reads 0, `wr_ready` is high and neither result pulse is active.
- R2: For each accepted write, exactly one of `wr_ok` or `wr_gp` is high for one cycle, in the cycle after the write. Neither pulse is high in any other cycle.
- R3: A mode-control write (`wr_sel`=0) whose data has bit 31 (paging) set and bit 0 (protection) clear raises `wr_gp`. Neither register changes.
- R4: When `long_mode` is high, a mode-control write with any of bits 63..32 nonzero raises `wr_gp` and is discarded. When `long_mode` is low, those bits are ignored.
- R5: An accepted mode-control write updates only bits 31, 30, 29, 18, 16 and 5..0. Every other bit keeps its stored value. Bit 29 reads back as written but drives no output.
- R6: A feature write (`wr_sel`=1) with any bit 63..11 set raises `wr_gp` and is discarded. Otherwise bits 10..0 are stored and bits 63..11 stay zero.
- R7: `tsc_read_ok` is high when feature bit 2 is clear, or when `cpl` is 0.
- R8: When feature bit 3 is set, a debug index of 4 or 5 drives `dr_ud` high and passes the index through unchanged. When feature bit 3 is clear, index 4 maps to 6 and index 5 maps to 7. All other indices pass through unchanged with `dr_ud` low.
- R9: `pse_en` equals feature bit 4 only while feature bit 5 is clear. It is 0 whenever bit 5 is set.
- R10: `paging_en`, `prot_en` and `cache_dis` follow mode bits 31, 0 and 30. `dbg_ext`, `tsd_en` and `pae_en` follow feature bits 3, 2 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write port ready, high outside reset |
| wr_sel | input | 1 | 0 selects mode-control, 1 selects feature register |
| wr_data | input | 64 | Write data |
| long_mode | input | 1 | Core currently runs in long mode |
| cpl | input | 2 | Current privilege level |
| wr_ok | output | 1 | Write accepted pulse |
| wr_gp | output | 1 | General-protection fault pulse |
| mode_q | output | 64 | Mode-control register contents |
| feat_q | output | 64 | Feature register contents |
| paging_en | output | 1 | Paging enable |
| prot_en | output | 1 | Protection enable |
| cache_dis | output | 1 | Cache disable |
| dbg_ext | output | 1 | Debug extensions enable |
| tsd_en | output | 1 | Time-stamp disable |
| pae_en | output | 1 | Physical-address extension enable |
| pse_en | output | 1 | Effective page-size extension |
| tsc_read_ok | output | 1 | Time-stamp read permitted |
| dr_idx | input | 3 | Requested debug register index |
| dr_idx_eff | output | 3 | Debug register index actually used |
| dr_ud | output | 1 | Access is an invalid-opcode case |

## Verification
The assertions assume the block sees clean two-state values on `wr_valid`, `wr_sel`, `wr_data`, `long_mode`, `cpl` and `dr_idx`. They also assume reset is held low for at least one clock edge before anything is judged. The properties that compare against the previous cycle are valid only because every write is checked in full before it is committed. The stimulus holds reset for several edges first. After that it changes inputs only at falling clock edges and always with defined values. It mixes legal and illegal words: paging without protection, nonzero upper halves with and without long mode, and out-of-range feature bits. This exercises every fault path against both registers.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;
  localparam int XLEN      = 64;
  localparam int HALF      = 32;
  localparam int PE_BIT    = 0;
  localparam int LEGACY_BIT = 29;
  localparam int CD_BIT    = 30;
  localparam int PG_BIT    = 31;
  localparam int TSD_BIT   = 2;
  localparam int DE_BIT    = 3;
  localparam int PSE_BIT   = 4;
  localparam int PAE_BIT   = 5;

  typedef enum logic {SEL_MODE = 1'b0, SEL_FEAT = 1'b1} regsel_e;

  // bits of the mode-control register that software may change
  function automatic logic [XLEN-1:0] mode_wmask();
    logic [XLEN-1:0] m;
    m = '0;
    for (int i = 0; i <= 5; i++) m[i] = 1'b1;
    m[16] = 1'b1;
    m[18] = 1'b1;
    m[LEGACY_BIT] = 1'b1;
    m[CD_BIT] = 1'b1;
    m[PG_BIT] = 1'b1;
    return m;
  endfunction

  function automatic logic [XLEN-1:0] low_ones(int n);
    logic [XLEN-1:0] m;
    m = '0;
    for (int i = 0; i < XLEN; i++) m[i] = (i < n);
    return m;
  endfunction
endpackage

// File: rtl/ctlreg_wcheck.sv
module ctlreg_wcheck
  import ctlreg_pkg::*;
#(
  parameter int FEAT_BITS = 11
) (
  input  logic            sel,
  input  logic [XLEN-1:0] data,
  input  logic            long_mode,
  output logic            fault
);
  logic pg_without_pe;
  logic upper_in_long;
  logic feat_oob;

  always_comb begin
    pg_without_pe = data[PG_BIT] & ~data[PE_BIT];
    upper_in_long = long_mode & (|data[XLEN-1:HALF]);
    feat_oob      = |data[XLEN-1:FEAT_BITS];
    if (regsel_e'(sel) == SEL_MODE) fault = pg_without_pe | upper_in_long;
    else                            fault = feat_oob;
  end
endmodule

// File: rtl/ctlreg_store.sv
module ctlreg_store
  import ctlreg_pkg::*;
#(
  parameter int FEAT_BITS = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic            sel,
  input  logic [XLEN-1:0] data,
  output logic [XLEN-1:0] mode_q,
  output logic [XLEN-1:0] feat_q
);
  localparam logic [XLEN-1:0] MODE_WM  = mode_wmask();
  localparam logic [XLEN-1:0] FEAT_WM  = low_ones(FEAT_BITS);
  localparam logic [XLEN-1:0] MODE_RST = XLEN'(1) << PE_BIT;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_RST;
      feat_q <= '0;
    end else if (we) begin
      if (regsel_e'(sel) == SEL_MODE)
        mode_q <= (mode_q & ~MODE_WM) | (data & MODE_WM);
      else
        feat_q <= data & FEAT_WM;
    end
  end

  AST_RSVD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q & ~MODE_WM) == ($past(mode_q) & ~MODE_WM)); // R5
  AST_FEAT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (feat_q & ~FEAT_WM) == '0); // R6
  AST_PG_NEEDS_PE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[PG_BIT] |-> mode_q[PE_BIT]); // R3
endmodule

// File: rtl/ctlreg_decode.sv
module ctlreg_decode
  import ctlreg_pkg::*;
#(
  parameter int CPL_W    = 2,
  parameter int DR_IDX_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [XLEN-1:0]     feat_q,
  input  logic [CPL_W-1:0]    cpl,
  input  logic [DR_IDX_W-1:0] dr_idx,
  output logic                tsd_en,
  output logic                dbg_ext,
  output logic                pae_en,
  output logic                pse_en,
  output logic                tsc_read_ok,
  output logic [DR_IDX_W-1:0] dr_idx_eff,
  output logic                dr_ud
);
  localparam logic [DR_IDX_W-1:0] ALIAS_A = DR_IDX_W'(4);
  localparam logic [DR_IDX_W-1:0] ALIAS_B = DR_IDX_W'(5);
  localparam logic [DR_IDX_W-1:0] SHIFT   = DR_IDX_W'(2);

  logic in_alias;

  always_comb begin
    tsd_en      = feat_q[TSD_BIT];
    dbg_ext     = feat_q[DE_BIT];
    pae_en      = feat_q[PAE_BIT];
    pse_en      = feat_q[PSE_BIT] & ~feat_q[PAE_BIT];
    tsc_read_ok = ~feat_q[TSD_BIT] | (cpl == '0);
    in_alias    = (dr_idx == ALIAS_A) | (dr_idx == ALIAS_B);
    dr_ud       = in_alias & feat_q[DE_BIT];
    dr_idx_eff  = (in_alias && !feat_q[DE_BIT]) ? dr_idx + SHIFT : dr_idx;
  end

  AST_TSC_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    !tsd_en |-> tsc_read_ok); // R7
  AST_UD_NEEDS_DE: assert property (@(posedge clk) disable iff (!rst_n)
    dr_ud |-> dbg_ext); // R8
  AST_PSE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    pae_en |-> !pse_en); // R9
endmodule

// File: rtl/ctl_regfile.sv
module ctl_regfile
  import ctlreg_pkg::*;
#(
  parameter int FEAT_BITS = 11,
  parameter int CPL_W     = 2,
  parameter int DR_IDX_W  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_valid,
  output logic                wr_ready,
  input  logic                wr_sel,
  input  logic [XLEN-1:0]     wr_data,
  input  logic                long_mode,
  input  logic [CPL_W-1:0]    cpl,
  output logic                wr_ok,
  output logic                wr_gp,
  output logic [XLEN-1:0]     mode_q,
  output logic [XLEN-1:0]     feat_q,
  output logic                paging_en,
  output logic                prot_en,
  output logic                cache_dis,
  output logic                dbg_ext,
  output logic                tsd_en,
  output logic                pae_en,
  output logic                pse_en,
  output logic                tsc_read_ok,
  input  logic [DR_IDX_W-1:0] dr_idx,
  output logic [DR_IDX_W-1:0] dr_idx_eff,
  output logic                dr_ud
);
  logic ready_q, ok_q, gp_q, accept, fault, commit;

  assign accept = wr_valid & ready_q;
  assign commit = accept & ~fault;

  ctlreg_wcheck #(.FEAT_BITS(FEAT_BITS)) u_check (
    .sel(wr_sel), .data(wr_data), .long_mode(long_mode), .fault(fault));

  ctlreg_store #(.FEAT_BITS(FEAT_BITS)) u_store (
    .clk(clk), .rst_n(rst_n), .we(commit), .sel(wr_sel), .data(wr_data),
    .mode_q(mode_q), .feat_q(feat_q));

  ctlreg_decode #(.CPL_W(CPL_W), .DR_IDX_W(DR_IDX_W)) u_decode (
    .clk(clk), .rst_n(rst_n), .feat_q(feat_q), .cpl(cpl), .dr_idx(dr_idx),
    .tsd_en(tsd_en), .dbg_ext(dbg_ext), .pae_en(pae_en), .pse_en(pse_en),
    .tsc_read_ok(tsc_read_ok), .dr_idx_eff(dr_idx_eff), .dr_ud(dr_ud));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      ok_q    <= 1'b0;
      gp_q    <= 1'b0;
    end else begin
      ready_q <= 1'b1;
      ok_q    <= commit;
      gp_q    <= accept & fault;
    end
  end

  assign wr_ready  = ready_q;
  assign wr_ok     = ok_q;
  assign wr_gp     = gp_q;
  assign paging_en = mode_q[PG_BIT];
  assign prot_en   = mode_q[PE_BIT];
  assign cache_dis = mode_q[CD_BIT];

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ok && wr_gp)); // R2
  AST_RESULT_HAS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok || wr_gp) |-> $past(wr_valid && wr_ready)); // R2
  AST_GP_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_gp |-> (mode_q == $past(mode_q) && feat_q == $past(feat_q))); // R3
  AST_PAGING_PROT: assert property (@(posedge clk) disable iff (!rst_n)
    paging_en |-> prot_en); // R3
endmodule

// File: tb/ctl_regfile_test.sv
module ctl_regfile_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] WMASK = 64'h0000_0000_E005_003F;

  logic clk = 0, rst_n = 0, wr_valid = 0, wr_sel = 0, long_mode = 0;
  logic [63:0] wr_data = '0;
  logic [1:0] cpl = '0;
  logic [2:0] dr_idx = '0;
  logic wr_ready, wr_ok, wr_gp, paging_en, prot_en, cache_dis, dbg_ext;
  logic tsd_en, pae_en, pse_en, tsc_read_ok, dr_ud;
  logic [63:0] mode_q, feat_q;
  logic [2:0] dr_idx_eff;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference state
  logic [63:0] r_mode = 64'h1, r_feat = '0;
  logic e_ok = 0, e_gp = 0, e_ready = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctl_regfile uut (.*);

  always @(posedge clk) begin
    if (!rst_n) begin
      r_mode = 64'h1; r_feat = '0; e_ok = 0; e_gp = 0; e_ready = 0;
    end else begin
      logic bad;
      e_ok = 0; e_gp = 0;
      if (wr_valid && e_ready) begin
        if (!wr_sel) bad = (wr_data[31] && !wr_data[0]) || (long_mode && wr_data[63:32] != 0);
        else         bad = wr_data[63:11] != 0;
        if (bad) e_gp = 1;
        else begin
          e_ok = 1;
          if (!wr_sel) r_mode = (r_mode & ~WMASK) | (wr_data & WMASK);
          else         r_feat = {53'b0, wr_data[10:0]};
        end
      end
      e_ready = 1;
    end
  end

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [2:0] ei; logic eu;
    eu = 0; ei = dr_idx;
    if (dr_idx == 4 || dr_idx == 5) begin
      if (r_feat[3]) eu = 1; else ei = dr_idx + 3'd2;
    end
    chk("R2", "wr_ok", 64'(wr_ok), 64'(e_ok));
    chk("R2", "wr_gp", 64'(wr_gp), 64'(e_gp));
    chk("R5", "mode_q", mode_q, r_mode);
    chk("R6", "feat_q", feat_q, r_feat);
    chk("R10", "enables", {58'b0, paging_en, prot_en, cache_dis, dbg_ext, tsd_en, pae_en},
        {58'b0, r_mode[31], r_mode[0], r_mode[30], r_feat[3], r_feat[2], r_feat[5]});
    chk("R9", "pse_en", 64'(pse_en), 64'(r_feat[4] & ~r_feat[5]));
    chk("R7", "tsc_read_ok", 64'(tsc_read_ok), 64'(!r_feat[2] || cpl == 0));
    chk("R8", "dr_idx_eff", 64'(dr_idx_eff), 64'(ei));
    chk("R8", "dr_ud", 64'(dr_ud), 64'(eu));
  endtask

  task automatic do_write(logic sel, logic [63:0] d, logic lm);
    wr_valid = 1; wr_sel = sel; wr_data = d; long_mode = lm;
    @(negedge clk); compare_all();
    wr_valid = 0;
    @(negedge clk); compare_all();
  endtask

  initial begin
    void'($urandom(7));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "mode_q reset", mode_q, 64'h1);
    chk("R1", "feat_q reset", feat_q, 64'h0);
    chk("R1", "wr_ready", 64'(wr_ready), 64'h1);
    chk("R1", "pulses", {62'b0, wr_ok, wr_gp}, 64'h0);
    compare_all();
    // R3: paging without protection
    do_write(0, 64'h8000_0000, 0);
    chk("R3", "gp after PG without PE", 64'(e_gp | wr_gp), 64'h0);
    do_write(0, 64'h8000_0001, 0);
    chk("R3", "paging set", 64'(paging_en), 64'h1);
    // R4: upper half in long mode vs legacy
    do_write(0, 64'h0000_0001_6000_0001, 1);
    chk("R4", "long-mode upper kept out", mode_q, 64'h8000_0001);
    do_write(0, 64'h0000_0001_6000_0001, 0);
    chk("R4", "legacy upper ignored", mode_q, 64'h6000_0001);
    // R5: reserved bits ignored
    do_write(0, 64'hFFFF_FFFF_FFFF_FFFF, 0);
    chk("R5", "writable bits only", mode_q, 64'hE005_003F);
    // R6: feature limits
    do_write(1, 64'h0000_0000_0000_0800, 0);
    chk("R6", "oob feature discarded", feat_q, 64'h0);
    do_write(1, 64'h0000_0000_0000_07FF, 0);
    chk("R6", "all features", feat_q, 64'h7FF);
    // R7 / R8 / R9 with features set
    for (int c = 0; c < 4; c++) begin
      cpl = 2'(c);
      for (int i = 0; i < 8; i++) begin
        dr_idx = 3'(i);
        @(negedge clk); compare_all();
      end
    end
    do_write(1, 64'h0000_0000_0000_0010, 0);
    chk("R9", "pse alone", 64'(pse_en), 64'h1);
    for (int i = 0; i < 8; i++) begin
      dr_idx = 3'(i); cpl = 2'(i);
      @(negedge clk); compare_all();
    end
    // mixed random traffic, including back-to-back writes
    for (int n = 0; n < 3000; n++) begin
      logic [63:0] d;
      wr_valid = ($urandom % 2) == 0;
      wr_sel = $urandom % 2;
      long_mode = $urandom % 2;
      cpl = 2'($urandom);
      dr_idx = 3'($urandom);
      d = {$urandom, $urandom};
      if (wr_sel) begin
        if ($urandom % 4 != 0) d = d & 64'h7FF;
      end else begin
        if ($urandom % 2 == 0) d[63:32] = '0;
        if ($urandom % 3 == 0) d[0] = 1'b1;
      end
      wr_data = d;
      @(negedge clk); compare_all();
    end
    wr_valid = 0;
    @(negedge clk); compare_all();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule